// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This block is the shift stage of a 32-bit integer pipeline. It receives a decoded instruction word and two register operands. From these it produces one 32-bit result in the same cycle. It covers left shift, logical right shift, arithmetic right shift and right rotate. Each operation has an immediate form, where the amount comes from a 5-bit field of the instruction, and a variable form, where the amount comes from the low bits of a register operand.

The unit decodes the 6-bit function field itself. A rotate has no function code of its own: it reuses the code of the matching logical right shift and is chosen by one extra instruction bit. That bit is at a different position in the immediate form and in the variable form. Codes the unit does not handle raise a flag and force the result to zero. A single register delays the caller's valid strobe by one cycle, so downstream logic can sample the result on a handshake.

Top module: `shift_rot_unit`

## Requirements
- R1: Function field `instr[5:0]` is decoded as follows: 0 is immediate left shift, 2 is immediate right shift or rotate, 3 is immediate arithmetic right shift, 4 is variable left shift, 6 is variable right shift or rotate, and 7 is variable arithmetic right shift. Any other code drives `invalidOp` high and `result` to zero. A handled code keeps `invalidOp` low.
- R2: A left shift moves `srcVal` toward the MSB and fills the vacated low bits with zeros.
- R3: With code 2 and `instr[21]` clear, the result is `srcVal` shifted right logically by the immediate amount `instr[10:6]`, with zeros filling the vacated high bits.
- R4: With code 2 and `instr[21]` set, the result is `srcVal` rotated right by `instr[10:6]`. Bits leaving the LSB re-enter at the MSB.
- R5: With code 6, `instr[6]` set selects a right rotate by the register amount, and `instr[6]` clear selects a logical right shift. With code 2, `instr[6]` is only the low bit of the amount. With code 6, `instr[21]` has no effect on the choice.
- R6: Every variable form uses only `srcAmt[4:0]` as its amount. Bits 31:5 of `srcAmt` have no effect, so an amount of 32 behaves as 0.
- R7: Arithmetic right shift fills the vacated high bits with copies of `srcVal[31]`, in both the immediate and the variable form.
- R8: A rotate or shift by an amount of zero returns `srcVal` unchanged.
- R9: `outValid` equals `inValid` delayed by one clock, and it is low while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and instruction are valid this cycle |
| instr | input | 32 | Instruction word: function `[5:0]`, amount `[10:6]`, immediate rotate select `[21]` |
| srcAmt | input | 32 | Register operand that supplies the variable amount |
| srcVal | input | 32 | Register operand to be shifted or rotated |
| result | output | 32 | Combinational shift or rotate result |
| invalidOp | output | 1 | Function code is not handled |
| outValid | output | 1 | `inValid` delayed by one cycle |

## Verification
Two roles of the same instruction bit can fall in one cycle. Bit 6 is both the rotate select of the variable form and the low amount bit of the immediate form. Bit 21 selects rotate in the immediate form but lies in an operand field of the variable form. The bench provokes this with immediate right shifts that use odd amounts and with variable right shifts that have bit 21 set and bit 6 clear. A behavioural model judges each of these as a plain logical shift. The variable forms are also driven with amounts whose upper bits are set, including exactly 32, and each cycle is compared with the model.

// File: rtl/shift_rot_pkg.sv
package shift_rot_pkg;
  typedef enum logic [1:0] {
    OP_SHL = 2'd0,
    OP_SHR = 2'd1,
    OP_SRA = 2'd2,
    OP_ROR = 2'd3
  } shiftKind_e;

  typedef struct packed {
    shiftKind_e kind;
    logic       useReg;
    logic       invalid;
  } shiftCtl_t;
endpackage

// File: rtl/shift_rot_ctrl.sv
module shift_rot_ctrl
  import shift_rot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] funct,
  input  logic       immRotSel,
  input  logic       regRotSel,
  output shiftCtl_t  ctl
);
  always_comb begin
    ctl.kind    = OP_SHL;
    ctl.useReg  = 1'b0;
    ctl.invalid = 1'b0;
    unique case (funct)
      6'd0: ctl.kind = OP_SHL;
      6'd2: ctl.kind = immRotSel ? OP_ROR : OP_SHR;
      6'd3: ctl.kind = OP_SRA;
      6'd4: begin ctl.kind = OP_SHL; ctl.useReg = 1'b1; end
      6'd6: begin ctl.kind = regRotSel ? OP_ROR : OP_SHR; ctl.useReg = 1'b1; end
      6'd7: begin ctl.kind = OP_SRA; ctl.useReg = 1'b1; end
      default: ctl.invalid = 1'b1;
    endcase
  end

  // R5
  reg_rot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (funct == 6'd6 && !regRotSel) |-> (ctl.kind == OP_SHR && ctl.useReg));

  // R1
  code_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (funct[5:3] != 3'd0) |-> ctl.invalid);
endmodule

// File: rtl/shift_rot_datapath.sv
module shift_rot_datapath
  import shift_rot_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  shiftCtl_t        ctl,
  input  logic [AMT_W-1:0] immAmt,
  input  logic [AMT_W-1:0] regAmt,
  input  logic [WIDTH-1:0] value,
  output logic [WIDTH-1:0] result
);
  logic [AMT_W-1:0] amt;
  logic [WIDTH-1:0] revIn;
  logic [WIDTH-1:0] revOut;
  logic [WIDTH-1:0] stageIn;
  logic             fillBit;
  logic             isLeft;
  logic             isRot;
  logic [WIDTH-1:0] stg [AMT_W+1];

  assign amt     = ctl.useReg ? regAmt : immAmt;
  assign isLeft  = (ctl.kind == OP_SHL);
  assign isRot   = (ctl.kind == OP_ROR);
  assign fillBit = (ctl.kind == OP_SRA) ? value[WIDTH-1] : 1'b0;

  // left shift reuses the right-shift network on a bit-reversed word
  for (genvar b = 0; b < WIDTH; b++) begin : g_rev
    assign revIn[b]  = value[WIDTH-1-b];
    assign revOut[b] = stg[AMT_W][WIDTH-1-b];
  end

  assign stageIn = isLeft ? revIn : value;
  assign stg[0]  = stageIn;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    logic [STEP-1:0] topBits;
    assign topBits = isRot ? stg[s][STEP-1:0] : {STEP{fillBit}};
    assign stg[s+1] = amt[s] ? {topBits, stg[s][WIDTH-1:STEP]} : stg[s];
  end

  always_comb begin
    if (ctl.invalid)   result = '0;
    else if (isLeft)   result = revOut;
    else               result = stg[AMT_W];
  end

  // R8
  zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.invalid && amt == '0) |-> (result == value));

  // R4
  rot_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.invalid && isRot) |-> ($countones(result) == $countones(value)));

  // R7
  sra_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.invalid && ctl.kind == OP_SRA) |-> (result[WIDTH-1] == value[WIDTH-1]));

  // R2
  shl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.invalid && isLeft && amt != '0) |-> (result[0] == 1'b0));

  // R3
  shr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.invalid && ctl.kind == OP_SHR && amt != '0) |-> (result[WIDTH-1] == 1'b0));
endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
  import shift_rot_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic [31:0]      instr,
  input  logic [WIDTH-1:0] srcAmt,
  input  logic [WIDTH-1:0] srcVal,
  output logic [WIDTH-1:0] result,
  output logic             invalidOp,
  output logic             outValid
);
  shiftCtl_t ctl;
  logic      unusedBits;

  assign unusedBits = ^{instr[31:22], instr[20:11], srcAmt[WIDTH-1:AMT_W]};

  shift_rot_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .funct     (instr[5:0]),
    .immRotSel (instr[21]),
    .regRotSel (instr[6]),
    .ctl       (ctl)
  );

  shift_rot_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .immAmt (instr[6 +: AMT_W]),
    .regAmt (srcAmt[AMT_W-1:0]),
    .value  (srcVal),
    .result (result)
  );

  assign invalidOp = ctl.invalid;

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

  // R9
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  // R1
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalidOp |-> (result == '0));
endmodule

// File: tb/shift_rot_unit_bench.sv
module shift_rot_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] srcAmt = '0;
  logic [31:0] srcVal = '0;
  logic [31:0] result;
  logic        invalidOp;
  logic        outValid;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit lastIn = 0;

  always #2 clk = ~clk;

  shift_rot_unit u_shift_rot_unit (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .instr(instr),
    .srcAmt(srcAmt), .srcVal(srcVal), .result(result),
    .invalidOp(invalidOp), .outValid(outValid)
  );

  function automatic logic [31:0] mk(input logic [5:0] f, input logic [4:0] sa, input logic b21);
    return {10'h0, b21, 10'h0, sa, f};
  endfunction

  function automatic logic [31:0] model(input logic [31:0] ins, input logic [31:0] a,
                                        input logic [31:0] v, output bit inv);
    int n;
    logic [31:0] r;
    inv = 0;
    n = (ins[5:0] >= 6'd4) ? int'(a % 32) : int'(ins[10:6]);
    r = v;
    case (ins[5:0])
      6'd0, 6'd4: r = v << n;
      6'd3, 6'd7: r = $unsigned($signed(v) >>> n);
      6'd2, 6'd6: begin
        if ((ins[5:0] == 6'd2 && ins[21]) || (ins[5:0] == 6'd6 && ins[6])) begin
          for (int k = 0; k < n; k++) r = {r[0], r[31:1]};
        end else r = v >> n;
      end
      default: begin inv = 1; r = 0; end
    endcase
    return r;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [31:0] ins, input logic [31:0] a, input logic [31:0] v);
    bit inv;
    logic [31:0] exp;
    @(negedge clk);
    check("R9", "outValid", {31'h0, outValid}, {31'h0, lastIn});
    instr = ins; srcAmt = a; srcVal = v; inValid = 1'b1;
    lastIn = 1'b1;
    #1;
    exp = model(ins, a, v, inv);
    check(req, "result", result, exp);
    check(inv ? "R1" : req, "invalidOp", {31'h0, invalidOp}, {31'h0, inv});
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "outValid in reset", {31'h0, outValid}, 32'h0);
    rst_n = 1'b1;
    // R2 left shifts, immediate and variable
    apply("R2", mk(6'd0, 5'd1, 1'b0), 32'h0, 32'h8000_0001);
    apply("R2", mk(6'd0, 5'd31, 1'b0), 32'h0, 32'hFFFF_FFFF);
    apply("R2", mk(6'd4, 5'd0, 1'b0), 32'd4, 32'h1234_5678);
    // R3 logical right, odd amounts put bit 6 high
    apply("R3", mk(6'd2, 5'd1, 1'b0), 32'h0, 32'h8000_0000);
    apply("R3", mk(6'd2, 5'd31, 1'b0), 32'h0, 32'hFFFF_FFFF);
    // R4 immediate rotate
    apply("R4", mk(6'd2, 5'd1, 1'b1), 32'h0, 32'h0000_0001);
    apply("R4", mk(6'd2, 5'd31, 1'b1), 32'h0, 32'h8000_0001);
    apply("R4", mk(6'd2, 5'd8, 1'b1), 32'h0, 32'hDEAD_BEEF);
    // R5 variable rotate select and bit 21 ignored
    apply("R5", mk(6'd6, 5'd1, 1'b0), 32'd4, 32'hDEAD_BEEF);
    apply("R5", mk(6'd6, 5'd0, 1'b1), 32'd4, 32'hDEAD_BEEF);
    apply("R5", mk(6'd6, 5'd1, 1'b1), 32'd31, 32'h8000_0001);
    // R6 upper amount bits ignored, 32 acts as 0
    apply("R6", mk(6'd6, 5'd1, 1'b0), 32'd32, 32'hCAFE_F00D);
    apply("R6", mk(6'd4, 5'd0, 1'b0), 32'hFFFF_FFE1, 32'h0000_0003);
    apply("R6", mk(6'd7, 5'd0, 1'b0), 32'h8000_0004, 32'h8000_0000);
    apply("R6", mk(6'd6, 5'd0, 1'b0), 32'h0000_0020, 32'hFFFF_0000);
    // R7 arithmetic right, both forms
    apply("R7", mk(6'd3, 5'd31, 1'b0), 32'h0, 32'h8000_0000);
    apply("R7", mk(6'd3, 5'd4, 1'b0), 32'h0, 32'h7000_0000);
    apply("R7", mk(6'd7, 5'd0, 1'b0), 32'd1, 32'hF000_000F);
    // R8 zero amounts
    apply("R8", mk(6'd2, 5'd0, 1'b1), 32'h0, 32'hA5A5_0F0F);
    apply("R8", mk(6'd6, 5'd1, 1'b0), 32'd0, 32'h1357_9BDF);
    apply("R8", mk(6'd7, 5'd0, 1'b0), 32'd64, 32'h8765_4321);
    // R1 unhandled codes
    apply("R1", mk(6'd1, 5'd3, 1'b0), 32'd1, 32'hFFFF_FFFF);
    apply("R1", mk(6'd5, 5'd3, 1'b1), 32'd1, 32'hFFFF_FFFF);
    apply("R1", mk(6'd8, 5'd3, 1'b0), 32'd1, 32'hFFFF_FFFF);
    apply("R1", mk(6'd63, 5'd3, 1'b0), 32'd1, 32'hFFFF_FFFF);
    // random mix of all six operations
    for (int i = 0; i < 400; i++) begin
      logic [5:0] f;
      int pick = $urandom_range(0, 5);
      f = (pick == 0) ? 6'd0 : (pick == 1) ? 6'd2 : (pick == 2) ? 6'd3 :
          (pick == 3) ? 6'd4 : (pick == 4) ? 6'd6 : 6'd7;
      apply((pick == 1 || pick == 4) ? "R5" : (pick == 2 || pick == 5) ? "R7" : "R2",
            {$urandom} & 32'hFFFF_FFC0 | {26'h0, f}, $urandom, $urandom);
    end
    // R9 idle cycle drops outValid
    @(negedge clk);
    check("R9", "outValid", {31'h0, outValid}, {31'h0, lastIn});
    inValid = 1'b0; lastIn = 1'b0;
    @(negedge clk);
    check("R9", "outValid idle", {31'h0, outValid}, 32'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule